// File: doc/BRIEF.md
# Enhanced Configuration Window Decoder

This block holds the 64-bit base register for the memory-mapped PCI Express configuration window. A byte-enabled configuration write port updates the register. Each write whose bytes land on the register re-derives three values: whether the window is live, its aligned base and its size. After reset the block derives the same values from a fixed default. The decoded values are kept in flops, so the memory-side decode does not sit behind the register's write logic.

On the memory side, every incoming physical address is compared against the live window. On a hit, the offset into the window is split into the target bus, device, function and register number. Bus bits that lie above the window size read as zero. The block also gives the start of the 32-bit PCI hole. When the window is live, the hole starts just past the window. Otherwise it starts at the default base.

A length code that is not legal disables the window and raises a sticky error flag. Forwarding the configuration transaction is left to the logic that consumes the hit and the split offset.

Top module: `mmcfg_decoder`

## Requirements
- R1: After reset the register holds its default value (enable bit 0, length code 00, base 0xB000_0000). The window is then off, `win_base` reads 0xB000_0000, `hole_start` reads 0xB000_0000 and `len_err` is 0.
- R2: A write to the dword at byte offset REG_OFS updates register bits [31:0], and a write to REG_OFS+4 updates bits [63:32]. Only the bytes whose `cfg_wr_be` bit is set change. The decoded outputs take the new value one clock edge after the write.
- R3: A write to any other dword, or a write with all byte enables clear, leaves every decoded output unchanged.
- R4: Register bit 0 is the enable. While the window is off, `mem_hit` stays low for every address.
- R5: Register bits [2:1] give the length code. Code 00 selects 256 MB, with base bits [35:28]. Code 01 selects 128 MB, with base bits [35:27]. Code 10 selects 64 MB, with base bits [35:26]. Base bits below the window size read as zero on `win_base`.
- R6: Length code 11 is reserved. It turns the window off even when the enable bit is set.
- R7: `len_err` goes high on the edge after a write that leaves length code 11 in the register. It stays high, whatever is written later, until reset.
- R8: `hole_start` equals `win_base` plus the window size while the window is on. Otherwise it equals the default base 0xB000_0000.
- R9: `mem_hit` is high exactly when the window is on and `win_base <= mem_addr < win_base + size`.
- R10: On a hit the offset `mem_addr - win_base` splits into `tgt_bus` = offset[27:20], `tgt_dev` = offset[19:15], `tgt_fn` = offset[14:12] and `tgt_reg` = offset[11:0]. `tgt_bus[7]` is zero at 128 MB and `tgt_bus[7:6]` is zero at 64 MB. With no hit, all four fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | CFG_AW | Byte address of the written dword |
| cfg_wr_data | input | 32 | Write data |
| cfg_wr_be | input | 4 | Byte enables of the dword |
| mem_addr | input | PA_W | Physical address to decode |
| win_en | output | 1 | Window is live |
| win_len | output | 2 | Decoded length code |
| win_base | output | PA_W | Aligned window base |
| hole_start | output | PA_W+1 | Start of the 32-bit PCI hole |
| len_err | output | 1 | Sticky reserved-length error |
| mem_hit | output | 1 | `mem_addr` falls inside the window |
| tgt_bus | output | 8 | Bus number from the offset |
| tgt_dev | output | 5 | Device number from the offset |
| tgt_fn | output | 3 | Function number from the offset |
| tgt_reg | output | 12 | Register offset inside the function |

## Verification
The bench probes the addresses just below the base, at the base, at the last byte of the window and one byte past it, for each of the three sizes. An off-by-one in the range compare or a mask one bit too narrow would show up as a wrong `mem_hit` or a base with bit 27 or 26 left set. The bench also writes a base whose low mask bits are set and then shrinks the window, so a design that re-masked only at 256 MB or forgot to force the upper bus bits would give a wrong `win_base`, `hole_start` or `tgt_bus`. Writes to the neighbouring dword, writes with no byte enables and a reserved length followed by a legal one check that unrelated traffic changes nothing and that the error flag stays set.

// File: rtl/mmcfg_pkg.sv
package mmcfg_pkg;

  // Size of the largest window as a power of two (256 MB).
  localparam int SZ_LG_MAX = 28;
  // Field positions inside the base register.
  localparam int EN_BIT = 0;
  localparam int LEN_LO = 1;
  localparam int LEN_HI = 2;
  localparam int BUS_W  = 8;

  typedef enum logic [1:0] {
    WIN_256  = 2'b00,
    WIN_128  = 2'b01,
    WIN_64   = 2'b10,
    WIN_RSVD = 2'b11
  } win_len_e;

  // log2 of the window size. The reserved code keeps the widest mask.
  function automatic int size_lg(input win_len_e l);
    case (l)
      WIN_128: size_lg = SZ_LG_MAX - 1;
      WIN_64:  size_lg = SZ_LG_MAX - 2;
      default: size_lg = SZ_LG_MAX;
    endcase
  endfunction

endpackage

// File: rtl/mmcfg_cfg_reg.sv
module mmcfg_cfg_reg #(
  parameter int              CFG_AW  = 12,
  parameter int              REG_OFS = 'h60,
  parameter int              REG_W   = 64,
  parameter logic [REG_W-1:0] DFLT   = 64'h0000_0000_B000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        wr_be,
  output logic [REG_W-1:0]  reg_n,
  output logic              upd
);

  localparam int NDW    = REG_W / 32;
  localparam int NBYTE  = REG_W / 8;
  localparam int DW_IDX = REG_OFS / 4;

  logic [REG_W-1:0] reg_q;
  logic [NDW-1:0]   dw_sel;
  logic [NBYTE-1:0] byte_we;
  logic             unused_lsb;

  assign unused_lsb = ^wr_addr[1:0];

  for (genvar d = 0; d < NDW; d++) begin : g_dw
    localparam logic [CFG_AW-3:0] IDX = (CFG_AW-2)'(DW_IDX + d);
    assign dw_sel[d] = wr_en & (wr_addr[CFG_AW-1:2] == IDX);
  end

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    assign byte_we[b]        = dw_sel[b/4] & wr_be[b%4];
    assign reg_n[b*8 +: 8]   = byte_we[b] ? wr_data[(b%4)*8 +: 8] : reg_q[b*8 +: 8];
  end

  assign upd = |byte_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   reg_q <= DFLT;
    else if (upd) reg_q <= reg_n;
  end

endmodule

// File: rtl/mmcfg_win_eval.sv
module mmcfg_win_eval
  import mmcfg_pkg::*;
#(
  parameter int               PA_W  = 36,
  parameter int               REG_W = 64,
  parameter logic [REG_W-1:0] DFLT  = 64'h0000_0000_B000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [REG_W-1:0] reg_n,
  output logic             en_q,
  output win_len_e         len_q,
  output logic [PA_W-1:0]  base_q,
  output logic [PA_W:0]    hole_q,
  output logic             err_q
);

  localparam logic [PA_W-1:0] DFLT_BASE = DFLT[PA_W-1:0] & ({PA_W{1'b1}} << SZ_LG_MAX);

  typedef struct packed {
    logic            en;
    win_len_e        len;
    logic [PA_W-1:0] base;
    logic [PA_W:0]   hole;
  } win_t;

  function automatic win_t decode(input logic [REG_W-1:0] r);
    win_t            w;
    int              lg;
    logic [PA_W-1:0] msk;
    w.len  = win_len_e'(r[LEN_HI:LEN_LO]);
    lg     = size_lg(w.len);
    w.en   = r[EN_BIT] & (w.len != WIN_RSVD);
    msk    = {PA_W{1'b1}} << lg;
    w.base = r[PA_W-1:0] & msk;
    w.hole = w.en ? ({1'b0, w.base} + ((PA_W+1)'(1) << lg)) : {1'b0, DFLT_BASE};
    return w;
  endfunction

  win_t win_q, win_n;
  logic err_n;
  logic unused_hi;

  assign unused_hi = ^reg_n[REG_W-1:PA_W];

  always_comb begin
    win_n = upd ? decode(reg_n) : win_q;
    err_n = err_q | (upd & (reg_n[LEN_HI:LEN_LO] == WIN_RSVD));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= decode(DFLT);
      err_q <= 1'b0;
    end else begin
      win_q <= win_n;
      err_q <= err_n;
    end
  end

  assign en_q   = win_q.en;
  assign len_q  = win_q.len;
  assign base_q = win_q.base;
  assign hole_q = win_q.hole;

endmodule

// File: rtl/mmcfg_addr_dec.sv
module mmcfg_addr_dec
  import mmcfg_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  logic             en,
  input  win_len_e         len,
  input  logic [PA_W-1:0]  base,
  input  logic [PA_W-1:0]  addr,
  output logic             hit,
  output logic [BUS_W-1:0] bus,
  output logic [4:0]       dev,
  output logic [2:0]       fn,
  output logic [11:0]      regofs
);

  logic [PA_W-1:0]  off;
  logic [PA_W-1:0]  diff;
  logic [BUS_W-1:0] bus_msk;
  logic             unused_off;
  int               lg;

  assign unused_off = ^off[PA_W-1:SZ_LG_MAX];

  always_comb begin
    lg      = size_lg(len);
    off     = addr - base;
    diff    = (addr ^ base) >> lg;
    hit     = en & (diff == '0);
    bus_msk = {BUS_W{1'b1}} >> (SZ_LG_MAX - lg);
    if (hit) begin
      bus    = off[SZ_LG_MAX-1:20] & bus_msk;
      dev    = off[19:15];
      fn     = off[14:12];
      regofs = off[11:0];
    end else begin
      bus    = '0;
      dev    = '0;
      fn     = '0;
      regofs = '0;
    end
  end

endmodule

// File: rtl/mmcfg_decoder.sv
module mmcfg_decoder
  import mmcfg_pkg::*;
#(
  parameter int           PA_W    = 36,
  parameter int           CFG_AW  = 12,
  parameter int           REG_OFS = 'h60,
  parameter logic [63:0]  DFLT    = 64'h0000_0000_B000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_wr_addr,
  input  logic [31:0]       cfg_wr_data,
  input  logic [3:0]        cfg_wr_be,
  input  logic [PA_W-1:0]   mem_addr,
  output logic              win_en,
  output logic [1:0]        win_len,
  output logic [PA_W-1:0]   win_base,
  output logic [PA_W:0]     hole_start,
  output logic              len_err,
  output logic              mem_hit,
  output logic [7:0]        tgt_bus,
  output logic [4:0]        tgt_dev,
  output logic [2:0]        tgt_fn,
  output logic [11:0]       tgt_reg
);

  localparam int REG_W = 64;

  logic [REG_W-1:0] reg_n;
  logic             reg_upd;
  win_len_e         len_q;

  mmcfg_cfg_reg #(
    .CFG_AW (CFG_AW),
    .REG_OFS(REG_OFS),
    .REG_W  (REG_W),
    .DFLT   (DFLT)
  ) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr_en),
    .wr_addr(cfg_wr_addr),
    .wr_data(cfg_wr_data),
    .wr_be  (cfg_wr_be),
    .reg_n  (reg_n),
    .upd    (reg_upd)
  );

  mmcfg_win_eval #(
    .PA_W (PA_W),
    .REG_W(REG_W),
    .DFLT (DFLT)
  ) u_eval (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (reg_upd),
    .reg_n (reg_n),
    .en_q  (win_en),
    .len_q (len_q),
    .base_q(win_base),
    .hole_q(hole_start),
    .err_q (len_err)
  );

  assign win_len = len_q;

  mmcfg_addr_dec #(
    .PA_W(PA_W)
  ) u_dec (
    .en    (win_en),
    .len   (len_q),
    .base  (win_base),
    .addr  (mem_addr),
    .hit   (mem_hit),
    .bus   (tgt_bus),
    .dev   (tgt_dev),
    .fn    (tgt_fn),
    .regofs(tgt_reg)
  );

endmodule

// File: rtl/mmcfg_decoder_chk.sv
module mmcfg_decoder_chk #(
  parameter int          PA_W    = 36,
  parameter int          CFG_AW  = 12,
  parameter int          REG_OFS = 'h60,
  parameter logic [63:0] DFLT    = 64'h0000_0000_B000_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [CFG_AW-1:0] cfg_wr_addr,
  input logic [3:0]        cfg_wr_be,
  input logic              win_en,
  input logic [1:0]        win_len,
  input logic [PA_W-1:0]   win_base,
  input logic [PA_W:0]     hole_start,
  input logic              len_err,
  input logic              mem_hit,
  input logic [7:0]        tgt_bus,
  input logic [4:0]        tgt_dev,
  input logic [2:0]        tgt_fn,
  input logic [11:0]       tgt_reg
);

  localparam logic [CFG_AW-3:0] DW0 = (CFG_AW-2)'(REG_OFS / 4);
  localparam logic [CFG_AW-3:0] DW1 = (CFG_AW-2)'(REG_OFS / 4 + 1);
  localparam logic [PA_W:0] DFLT_HOLE =
    {1'b0, DFLT[PA_W-1:0] & ({PA_W{1'b1}} << 28)};

  logic quiet_wr;
  assign quiet_wr = cfg_wr_en &
    (((cfg_wr_addr[CFG_AW-1:2] != DW0) & (cfg_wr_addr[CFG_AW-1:2] != DW1)) | (cfg_wr_be == 4'h0));

  AST_QUIET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_wr |=> ($stable(win_en) && $stable(win_len) && $stable(win_base) && $stable(hole_start))); // R3
  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> !mem_hit); // R4
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    win_base[25:0] == 26'd0); // R5
  AST_RSVD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (win_len == 2'b11) |-> !win_en); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> len_err); // R7
  AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(len_err) |-> $past(cfg_wr_en)); // R7
  AST_HOLE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> (hole_start == DFLT_HOLE)); // R8
  AST_IDLE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_hit |-> (tgt_bus == 8'd0 && tgt_dev == 5'd0 && tgt_fn == 3'd0 && tgt_reg == 12'd0)); // R10
  AST_BUS_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_hit && win_len == 2'b10) |-> (tgt_bus[7:6] == 2'b00)); // R10

endmodule

bind mmcfg_decoder mmcfg_decoder_chk #(
  .PA_W(PA_W), .CFG_AW(CFG_AW), .REG_OFS(REG_OFS), .DFLT(DFLT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
  .cfg_wr_be(cfg_wr_be), .win_en(win_en), .win_len(win_len), .win_base(win_base),
  .hole_start(hole_start), .len_err(len_err), .mem_hit(mem_hit), .tgt_bus(tgt_bus),
  .tgt_dev(tgt_dev), .tgt_fn(tgt_fn), .tgt_reg(tgt_reg)
);

// File: tb/mmcfg_decoder_bench.sv
module mmcfg_decoder_bench;

  localparam int PA_W   = 36;
  localparam int CFG_AW = 12;
  localparam int OFS    = 'h60;
  localparam longint DFLT_BASE = 64'hB000_0000;
  localparam longint AMASK     = 64'hF_FFFF_FFFF;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_wr_en = 1'b0;
  logic [CFG_AW-1:0] cfg_wr_addr = '0;
  logic [31:0]       cfg_wr_data = '0;
  logic [3:0]        cfg_wr_be = '0;
  logic [PA_W-1:0]   mem_addr = '0;
  logic              win_en, len_err, mem_hit;
  logic [1:0]        win_len;
  logic [PA_W-1:0]   win_base;
  logic [PA_W:0]     hole_start;
  logic [7:0]        tgt_bus;
  logic [4:0]        tgt_dev;
  logic [2:0]        tgt_fn;
  logic [11:0]       tgt_reg;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  mmcfg_decoder u_mmcfg_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .cfg_wr_be(cfg_wr_be), .mem_addr(mem_addr),
    .win_en(win_en), .win_len(win_len), .win_base(win_base), .hole_start(hole_start),
    .len_err(len_err), .mem_hit(mem_hit), .tgt_bus(tgt_bus), .tgt_dev(tgt_dev),
    .tgt_fn(tgt_fn), .tgt_reg(tgt_reg)
  );

  // ---------------- behavioural reference ----------------
  logic [63:0] m_reg;
  bit          m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg <= 64'hB000_0000;
      m_err <= 1'b0;
    end else if (cfg_wr_en) begin
      logic [63:0] t;
      int dw, sel;
      bit touched;
      t = m_reg;
      touched = 0;
      dw = int'(cfg_wr_addr) / 4;
      sel = (dw == OFS / 4) ? 0 : (dw == OFS / 4 + 1) ? 1 : -1;
      if (sel >= 0) begin
        for (int b = 0; b < 4; b++) begin
          if (cfg_wr_be[b]) begin
            t[sel*32 + b*8 +: 8] = cfg_wr_data[b*8 +: 8];
            touched = 1;
          end
        end
      end
      m_reg <= t;
      if (touched && t[2:1] == 2'b11) m_err <= 1'b1;
    end
  end

  function automatic longint m_size();
    case (m_reg[2:1])
      2'b01:   return 64'h800_0000;
      2'b10:   return 64'h400_0000;
      default: return 64'h1000_0000;
    endcase
  endfunction

  function automatic bit m_en();
    return m_reg[0] && (m_reg[2:1] != 2'b11);
  endfunction

  function automatic longint m_base();
    longint raw;
    raw = longint'(m_reg) & AMASK;
    return raw - (raw % m_size());
  endfunction

  function automatic longint m_hole();
    return m_en() ? m_base() + m_size() : DFLT_BASE;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the reference on every falling edge once out of reset.
  always @(negedge clk) begin
    if (rst_n) begin
      longint a, off;
      bit h;
      a   = longint'(mem_addr);
      h   = m_en() && (a >= m_base()) && (a < m_base() + m_size());
      off = h ? a - m_base() : 0;
      chk("R4/R6 win_en", longint'(win_en), longint'(m_en()));
      chk("R5 win_base", longint'(win_base), m_base());
      chk("R8 hole_start", longint'(hole_start), m_hole());
      chk("R7 len_err", longint'(len_err), longint'(m_err));
      chk("R9 mem_hit", longint'(mem_hit), longint'(h));
      chk("R10 fields", {28'd0, tgt_bus, tgt_dev, tgt_fn, tgt_reg},
          {36'd0, off[27:0]});
    end
  end

  // ---------------- stimulus ----------------
  task automatic cfg_write(input int addr, input logic [31:0] data, input logic [3:0] be);
    @(negedge clk); #1;
    cfg_wr_en = 1'b1; cfg_wr_addr = CFG_AW'(addr); cfg_wr_data = data; cfg_wr_be = be;
    @(negedge clk); #1;
    cfg_wr_en = 1'b0; cfg_wr_be = 4'h0;
  endtask

  task automatic probe(input longint a);
    @(negedge clk); #1;
    mem_addr = PA_W'(a & AMASK);
  endtask

  task automatic sweep();
    longint b, s;
    b = m_base();
    s = m_size();
    probe(b); probe(b + 1); probe(b + s - 1); probe(b + s); probe(b - 1);
    probe(b + 64'h12_3456); probe(b + s / 2 + 64'h7ABC); probe(b + s - 64'h10_0000);
  endtask

  bit done = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    chk("R1 en", longint'(win_en), 0);
    chk("R1 base", longint'(win_base), 64'hB000_0000);
    chk("R1 hole", longint'(hole_start), 64'hB000_0000);
    chk("R1 err", longint'(len_err), 0);
    sweep();

    // R5: 256 MB, bit 27 set in data but outside the mask
    cfg_write(OFS, 32'hE800_0001, 4'hF);
    chk("R2 base after low write", longint'(win_base), 64'hE000_0000);
    chk("R8 hole 256M", longint'(hole_start), 64'hF000_0000);
    sweep();

    // R5: 128 MB by rewriting byte 0 only
    cfg_write(OFS, 32'h0000_0003, 4'h1);
    chk("R5 base 128M", longint'(win_base), 64'hE800_0000);
    chk("R8 hole 128M", longint'(hole_start), 64'hF000_0000);
    sweep();

    // R5: 64 MB with bit 26 set
    cfg_write(OFS, 32'hEC00_0005, 4'hF);
    chk("R5 base 64M", longint'(win_base), 64'hEC00_0000);
    probe(64'hEFF0_0000);
    @(negedge clk); #1;
    chk("R10 bus top bits 64M", longint'(tgt_bus), 64'h3F);
    sweep();

    // R3: neighbouring dword and empty byte enables
    cfg_write(OFS + 8, 32'h0000_0000, 4'hF);
    cfg_write(OFS - 4, 32'hFFFF_FFFF, 4'hF);
    cfg_write(OFS, 32'h0000_0000, 4'h0);
    chk("R3 base unchanged", longint'(win_base), 64'hEC00_0000);
    chk("R3 en unchanged", longint'(win_en), 1);

    // R6/R7: reserved length
    cfg_write(OFS, 32'hEC00_0007, 4'h1);
    chk("R6 reserved off", longint'(win_en), 0);
    chk("R7 err set", longint'(len_err), 1);
    chk("R8 hole default", longint'(hole_start), 64'hB000_0000);
    sweep();
    cfg_write(OFS, 32'hE000_0001, 4'hF);
    chk("R7 err sticky", longint'(len_err), 1);

    // R2: upper dword moves the base above 4 GB
    cfg_write(OFS + 4, 32'h0000_000A, 4'h1);
    chk("R2 high base", longint'(win_base), 64'hA_E000_0000);
    chk("R8 hole high", longint'(hole_start), 64'hA_F000_0000);
    probe(64'hA_E123_4567);
    @(negedge clk); #1;
    chk("R9 hit", longint'(mem_hit), 1);
    chk("R10 bus", longint'(tgt_bus), 64'h12);
    chk("R10 dev", longint'(tgt_dev), 6);
    chk("R10 fn", longint'(tgt_fn), 4);
    chk("R10 reg", longint'(tgt_reg), 64'h567);
    sweep();

    // R4: disable keeps base but stops hits
    cfg_write(OFS, 32'hE000_0000, 4'h1);
    probe(64'hA_E123_4567);
    @(negedge clk); #1;
    chk("R4 no hit when off", longint'(mem_hit), 0);
    sweep();

    // R1: reset clears the error and restores the default
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 err after reset", longint'(len_err), 0);
    chk("R1 base after reset", longint'(win_base), 64'hB000_0000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule